// File: doc/BRIEF.md
# Word-Addressed Memory Behind a Handshaked Target Port

This block is a small on-chip memory that answers single-cell transactions from an initiator. A transaction is offered on the command side with a valid strobe and taken when the block's command acknowledge is high. The block then performs a write into, or a read from, its internal word array. It returns exactly one response cell under a second valid/acknowledge pair. Only one transaction is in flight at a time. No new command is taken until the initiator has acknowledged the pending response.

Control is a three-state Moore machine: one idle state and two response states. The response states differ only in whether the accepted command closed its packet, and that flag is returned on the response side. Every output port is decoded from registered state. No port depends combinationally on an input, so the block can sit directly on a routed interconnect. Storage is indexed by the byte address with its two low bits dropped. Address bits above the array size wrap.

Top module: `memTargetPort`

## Requirements
- R1: While `rstN` is sampled low at a rising edge, the block returns to idle: from the next edge `cmdAck` is 1, `rspValid` is 0, `rspEop` is 0, and `rspRdata` is 0.
- R2: In idle with `cmdValid` low, the block stays idle: `cmdAck` stays 1 and `rspValid` stays 0. `cmdAck` and `rspValid` are never high together and never low together.
- R3: A command with `cmdValid` high at a rising edge while `cmdAck` is 1 is accepted. From that edge, `cmdAck` is 0 and `rspValid` is 1. A command presented while `cmdAck` is 0 is not accepted and does not touch the memory.
- R4: During a response, `rspEop` equals the `cmdEop` value of the accepted command and holds until the response ends.
- R5: `rspErr` is 0 at all times.
- R6: A response stays valid, with stable `rspEop` and `rspRdata`, until `rspAck` is sampled high. At that edge the block returns to idle, so `cmdAck` is 1 and `rspValid` is 0 in the following cycle.
- R7: An accepted command with `cmdWrite` = 1 stores `cmdWdata` at word index `(cmdAddr >> 2) mod DEPTH`. Address bits [1:0] and bits above the index are ignored.
- R8: An accepted command with `cmdWrite` = 0 returns on `rspRdata` the word held at its index at acceptance. A write response carries `rspRdata` = 0, and `rspRdata` is 0 whenever `rspValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | Initiator offers a command |
| cmdAck | output | 1 | Block can take a command this cycle |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | ADDR_W (32) | Byte address |
| cmdWdata | input | DATA_W (32) | Write data |
| cmdEop | input | 1 | Command closes its packet |
| rspValid | output | 1 | Response cell present |
| rspAck | input | 1 | Initiator takes the response |
| rspRdata | output | DATA_W (32) | Read data, 0 for write responses |
| rspErr | output | 1 | Error flag, always 0 |
| rspEop | output | 1 | Echo of the accepted command's end-of-packet flag |

## Verification
The bench holds `rspAck` low for several cycles while a second command with different data stays on the command pins. A design that samples commands while busy would overwrite memory or lose the held response, and a later read of that word exposes either fault. Addresses with nonzero low bits, and addresses that exceed the array and wrap, check the index derivation. A wrong shift or a missing wrap returns the wrong word. Both end-of-packet values are sent back to back with `rspAck` held high. This shows whether the flag is taken from the accepted command or from the live pin, and whether the block loses a cycle on its return to idle.

// File: rtl/memtgt_pkg.sv
package memtgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RSP     = 2'd1,
    ST_RSP_EOP = 2'd2
  } tgtState_e;

  // strobes from control to datapath, valid in the accepting cycle
  typedef struct packed {
    logic wrEn;
    logic rdLatch;
  } tgtStrobe_t;

endpackage

// File: rtl/memTgtCtrl.sv
module memTgtCtrl
  import memtgt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdWrite,
  input  logic       cmdEop,
  input  logic       rspAck,
  output tgtStrobe_t strb,
  output logic       cmdAck,
  output logic       rspValid,
  output logic       rspEop
);

  tgtState_e state, stateNext;
  logic      accept;

  assign accept = (state == ST_IDLE) && cmdValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (cmdValid) stateNext = cmdEop ? ST_RSP_EOP : ST_RSP;
      ST_RSP,
      ST_RSP_EOP: if (rspAck) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.wrEn    = accept && cmdWrite;
    strb.rdLatch = accept && !cmdWrite;
  end

  // Moore decode: state only
  assign cmdAck   = (state == ST_IDLE);
  assign rspValid = (state == ST_RSP) || (state == ST_RSP_EOP);
  assign rspEop   = (state == ST_RSP_EOP);

endmodule

// File: rtl/memTgtData.sv
module memTgtData
  import memtgt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tgtStrobe_t        strb,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdWord
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk) begin
    if (strb.wrEn) store[wordIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdReg <= '0;
    else if (strb.rdLatch) rdReg <= store[wordIdx];
    else if (strb.wrEn)    rdReg <= '0;
  end

  assign rdWord = rdReg;

endmodule

// File: rtl/memTargetPort.sv
module memTargetPort
  import memtgt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdAck,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic              cmdEop,
  output logic              rspValid,
  input  logic              rspAck,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  output logic              rspEop
);

  localparam int IDX_W = $clog2(DEPTH);

  tgtStrobe_t        strb;
  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] rdWord;
  logic              unusedAddrBits;

  assign wordIdx        = cmdAddr[IDX_W+1:2];
  assign unusedAddrBits = ^{cmdAddr[ADDR_W-1:IDX_W+2], cmdAddr[1:0]};

  memTgtCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdWrite (cmdWrite),
    .cmdEop   (cmdEop),
    .rspAck   (rspAck),
    .strb     (strb),
    .cmdAck   (cmdAck),
    .rspValid (rspValid),
    .rspEop   (rspEop)
  );

  memTgtData #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wordIdx (wordIdx),
    .wrData  (cmdWdata),
    .rdWord  (rdWord)
  );

  assign rspRdata = rspValid ? rdWord : '0;
  assign rspErr   = 1'b0;

endmodule

// File: rtl/memTargetPort_chk.sv
module memTargetPort_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdAck,
  input logic              cmdEop,
  input logic              rspValid,
  input logic              rspAck,
  input logic [DATA_W-1:0] rspRdata,
  input logic              rspErr,
  input logic              rspEop
);

  // R2
  ack_xor_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdAck != rspValid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAck && !cmdValid) |=> cmdAck);

  // R3
  accept_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAck && cmdValid) |=> (rspValid && !cmdAck));

  // R4
  eop_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAck && cmdValid) |=> (rspEop == $past(cmdEop)));

  // R5
  no_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspErr);

  // R6
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAck) |=> (rspValid && $stable(rspEop) && $stable(rspRdata)));

  // R6
  rsp_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspAck) |=> (cmdAck && !rspValid));

  // R8
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspRdata == '0));

endmodule

bind memTargetPort memTargetPort_chk #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdAck   (cmdAck),
  .cmdEop   (cmdEop),
  .rspValid (rspValid),
  .rspAck   (rspAck),
  .rspRdata (rspRdata),
  .rspErr   (rspErr),
  .rspEop   (rspEop)
);

// File: tb/memTargetPort_test.sv
`timescale 1ns/1ps
module memTargetPort_test;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdAck;
  logic        cmdWrite = 1'b0;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdWdata = '0;
  logic        cmdEop = 1'b0;
  logic        rspValid;
  logic        rspAck = 1'b0;
  logic [31:0] rspRdata;
  logic        rspErr;
  logic        rspEop;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  memTargetPort #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAck(cmdAck),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .cmdEop(cmdEop), .rspValid(rspValid), .rspAck(rspAck),
    .rspRdata(rspRdata), .rspErr(rspErr), .rspEop(rspEop)
  );

  // behavioural reference: 0 idle, 1 response, 2 response with packet end
  int          mState = 0;
  logic [31:0] mData = '0;
  logic [31:0] mMem [int];

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0;
      mData  = '0;
    end else if (mState == 0) begin
      if (cmdValid) begin
        int idx;
        idx = int'((cmdAddr >> 2) % DEPTH);
        mState = cmdEop ? 2 : 1;
        if (cmdWrite) begin
          mMem[idx] = cmdWdata;
          mData = '0;
        end else begin
          mData = mMem.exists(idx) ? mMem[idx] : 32'hDEAD_BEEF;
        end
      end
    end else if (rspAck) begin
      mState = 0;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      check("R2", "cmdAck", 32'(cmdAck), 32'(mState == 0));
      check("R3", "rspValid", 32'(rspValid), 32'(mState != 0));
      check("R4", "rspEop", 32'(rspEop), 32'(mState == 2));
      check("R5", "rspErr", 32'(rspErr), 32'h0);
      check("R8", "rspRdata", rspRdata, (mState != 0) ? mData : 32'h0);
    end
  end

  // one transaction; holdCycles = response cycles with rspAck low
  task automatic xfer(input logic wr, input logic [31:0] addr,
                      input logic [31:0] data, input logic eop,
                      input int holdCycles, input logic busyJunk);
    cmdValid = 1'b1; cmdWrite = wr; cmdAddr = addr; cmdWdata = data; cmdEop = eop;
    rspAck = (holdCycles == 0);
    @(negedge clk);
    if (busyJunk) begin
      // R3: command offered while busy must be ignored
      cmdWrite = 1'b1; cmdAddr = 32'h14; cmdWdata = 32'hBAD0_BAD0; cmdEop = ~eop;
    end else begin
      cmdValid = 1'b0;
    end
    for (int i = 0; i < holdCycles; i++) @(negedge clk);
    rspAck = 1'b1;
    cmdValid = 1'b0;
    @(negedge clk);
    rspAck = 1'b0;
  endtask

  task automatic runAll();
    repeat (3) @(negedge clk);
    // R1
    check("R1", "cmdAck in reset", 32'(cmdAck), 32'h1);
    check("R1", "rspValid in reset", 32'(rspValid), 32'h0);
    check("R1", "rspEop in reset", 32'(rspEop), 32'h0);
    check("R1", "rspRdata in reset", rspRdata, 32'h0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);   // R2 idle hold

    xfer(1'b1, 32'h14, 32'h1111_2222, 1'b1, 0, 1'b0);
    xfer(1'b1, 32'h0,  32'hA5A5_0001, 1'b0, 0, 1'b0);
    // R7: byte address 0x104 wraps onto word 1
    xfer(1'b1, 32'h104, 32'hCAFE_0101, 1'b1, 2, 1'b0);
    // R6/R3: long hold with a junk command on the pins
    xfer(1'b0, 32'h0, 32'h0, 1'b0, 5, 1'b1);
    xfer(1'b0, 32'h14, 32'h0, 1'b1, 3, 1'b1);
    // R7: low address bits ignored, word 1 via 0x007
    cmdValid = 1'b1; cmdWrite = 1'b0; cmdAddr = 32'h7; cmdEop = 1'b1; rspAck = 1'b0;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R7", "aliased read", rspRdata, 32'hCAFE_0101);
    check("R4", "eop echo", 32'(rspEop), 32'h1);
    rspAck = 1'b1;
    @(negedge clk);
    rspAck = 1'b0;
    check("R6", "idle after ack", 32'(cmdAck), 32'h1);

    // back-to-back with both packet-end values
    for (int k = 0; k < 8; k++)
      xfer(1'b1, 32'(k * 4 + 32'h80), 32'h5000_0000 + 32'(k), 1'(k & 1), 0, 1'b0);
    for (int k = 0; k < 8; k++)
      xfer(1'b0, 32'(k * 4 + 32'h80), 32'h0, 1'(~k & 1), k % 3, 1'b0);
    // R3: word 5 (0x14) still holds its first value despite busy junk
    xfer(1'b0, 32'h14, 32'h0, 1'b0, 1, 1'b0);

    // R1: reset in the middle of a response
    cmdValid = 1'b1; cmdWrite = 1'b0; cmdAddr = 32'h0; cmdEop = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "cmdAck after reset", 32'(cmdAck), 32'h1);
    check("R1", "rspEop after reset", 32'(rspEop), 32'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule